// File: doc/BRIEF.md
# SPI Clock-Calendar Register Port

This block is the serial front end of a small real-time-clock register file. A host talks to it over a four-wire SPI link with an active-high chip select. Every frame opens with one command byte. Its upper nibble picks a register and its lower nibble picks the access type: single or burst, read or write. Data bytes follow the command byte. Seven time registers (seconds through year) belong to an external timekeeping block. They reach this block as a flat input bus, and writes to them leave as a one-cycle strobe carrying an address and a data byte. Two control registers live inside the block. The second one holds two sticky status flags, raised by hardware pulses and cleared by software.

The serial pins are brought into the system clock domain through a short synchronizer. Edges are detected there. The serial clock must therefore be several times slower than the system clock. A burst read freezes all seven time registers at the moment its command byte completes, so a multi-byte read never mixes values from before and after a counter carry.

Top module: `rtc_spi_regif`

## Requirements
- R1: After reset, spi_miso is 0, tm_we is 0, ctl1_q is 0x00 and ctl2_q is 0x10 (oscillator-stop flag set).
- R2: The command byte carries the register address in bits 7:4. Bit 3 set means single access and bit 3 clear means burst. Bit 2 set means read and bit 2 clear means write. The four mode codes are therefore 0x8 single write, 0xC single read, 0x0 burst write and 0x4 burst read. Bits 1:0 are ignored.
- R3: The link uses SPI mode 1 with an active-high select. The block captures spi_mosi MSB first on the falling edge of spi_sclk and updates spi_miso after the rising edge. spi_miso reads 0 throughout the command byte and while the select is low.
- R4: A single read returns the addressed register in the first data byte. Bit 7 of seconds (address 0) always reads 0. Any further bytes in the same frame read 0.
- R5: A burst read returns consecutive addresses from the start address, ascending and wrapping 15 to 0. Time values come from a copy of all seven time registers taken when the command byte completes, and later changes on time_in are not seen in that frame.
- R6: A single write commits only the first data byte. For addresses 0 to 6 this gives one tm_we pulse, one cycle wide, with tm_waddr equal to the address and tm_wdata equal to the byte. Later bytes in the frame have no effect.
- R7: A burst write commits every complete data byte to the current address and then increments the address, wrapping from 15 to 0.
- R8: Addresses 7 to 13 read as 0 and ignore writes, with no tm_we pulse.
- R9: Address 14 is control register 1, a plain 8-bit register. It is readable, writable and visible on ctl1_q, and it changes only when written.
- R10: Address 15 is control register 2. Bit 4 (oscillator stop) and bit 6 (low voltage) are sticky flags. A pulse on osc_stop_set or low_volt_set sets the matching flag, and a set wins over a clear in the same cycle. A write of 0 to a flag bit clears that flag, and a write of 1 leaves it unchanged. The other bits take the written value.
- R11: Lowering the select ends the transaction. A partial byte is discarded with no commit, and the next frame starts again with a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs | input | 1 | Chip select, active high |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| time_in | input | 56 | Live time registers, byte k at bits 8k+7:8k (k = 0 seconds ... 6 year) |
| osc_stop_set | input | 1 | Pulse that sets the oscillator-stop flag |
| low_volt_set | input | 1 | Pulse that sets the low-voltage flag |
| tm_we | output | 1 | One-cycle write strobe to the time registers |
| tm_waddr | output | 3 | Time register index for tm_we |
| tm_wdata | output | 8 | Data for tm_we |
| ctl1_q | output | 8 | Control register 1 contents |
| ctl2_q | output | 8 | Control register 2 contents |

## Verification
The assertions assume that each level of spi_sclk and spi_cs lasts at least SYNC_STAGES+2 system clocks. They also assume that spi_mosi changes only on the rising serial edge and that the select toggles only while spi_sclk is low, so that the synchronized edges arrive in frame order. The stimulus holds every serial clock level for eight system clocks. It changes mosi together with the rising edge and keeps the select low for ten clocks between frames. Flag pulses are single-cycle and come only between frames.

// File: rtl/rtc_spi_regif.sv
module rtc_spi_regif #(
  parameter int          SYNC_STAGES = 2,
  parameter int          NUM_TIME    = 7,
  parameter logic [7:0]  CTL1_RESET  = 8'h00,
  parameter logic [7:0]  CTL2_RESET  = 8'h10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    spi_sclk,
  input  logic                    spi_cs,
  input  logic                    spi_mosi,
  output logic                    spi_miso,
  input  logic [NUM_TIME*8-1:0]   time_in,
  input  logic                    osc_stop_set,
  input  logic                    low_volt_set,
  output logic                    tm_we,
  output logic [2:0]              tm_waddr,
  output logic [7:0]              tm_wdata,
  output logic [7:0]              ctl1_q,
  output logic [7:0]              ctl2_q
);
  localparam logic [7:0] FLAG_MASK = 8'h50;
  localparam logic [3:0] CTL1_ADDR = 4'd14;
  localparam logic [3:0] CTL2_ADDR = 4'd15;
  localparam logic [3:0] TIME_LAST = 4'(NUM_TIME - 1);

  logic [SYNC_STAGES:0]   sclk_p;
  logic [SYNC_STAGES-1:0] cs_p, mosi_p;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_p <= '0;
      cs_p   <= '0;
      mosi_p <= '0;
    end else begin
      sclk_p <= {sclk_p[SYNC_STAGES-1:0], spi_sclk};
      cs_p   <= {cs_p[SYNC_STAGES-2:0], spi_cs};
      mosi_p <= {mosi_p[SYNC_STAGES-2:0], spi_mosi};
    end

  wire sclk_rise = sclk_p[SYNC_STAGES-1] & ~sclk_p[SYNC_STAGES];
  wire sclk_fall = ~sclk_p[SYNC_STAGES-1] & sclk_p[SYNC_STAGES];
  wire cs_on     = cs_p[SYNC_STAGES-1];
  wire mosi_s    = mosi_p[SYNC_STAGES-1];

  logic [2:0]            bit_cnt;
  logic [6:0]            rx_sh;
  logic [7:0]            tx_sh;
  logic                  have_cmd, is_read, is_single, used;
  logic [3:0]            addr;
  logic [NUM_TIME*8-1:0] shadow;

  wire [7:0] rx_byte   = {rx_sh, mosi_s};
  wire       byte_done = cs_on & sclk_fall & (bit_cnt == 3'd7);

  function automatic logic [7:0] rd_val(input logic [3:0] a, input logic [NUM_TIME*8-1:0] src,
                                        input logic [7:0] c1, input logic [7:0] c2);
    logic [7:0] v;
    if (a <= TIME_LAST) v = src[a*8 +: 8];
    else if (a == CTL1_ADDR) v = c1;
    else if (a == CTL2_ADDR) v = c2;
    else v = 8'h00;
    if (a == 4'd0) v[7] = 1'b0;
    return v;
  endfunction

  wire commit   = byte_done & have_cmd & ~is_read & ~(is_single & used);
  wire wr_time  = commit & (addr <= TIME_LAST);
  wire wr_ctl1  = commit & (addr == CTL1_ADDR);
  wire wr_ctl2  = commit & (addr == CTL2_ADDR);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      spi_miso  <= 1'b0;
      have_cmd  <= 1'b0;
      is_read   <= 1'b0;
      is_single <= 1'b0;
      used      <= 1'b0;
      addr      <= '0;
      shadow    <= '0;
    end else if (!cs_on) begin
      bit_cnt  <= '0;
      tx_sh    <= '0;
      spi_miso <= 1'b0;
      have_cmd <= 1'b0;
      used     <= 1'b0;
    end else begin
      if (sclk_rise) begin
        spi_miso <= tx_sh[7];
        tx_sh    <= {tx_sh[6:0], 1'b0};
      end
      if (sclk_fall) begin
        bit_cnt <= bit_cnt + 3'd1;
        rx_sh   <= {rx_sh[5:0], mosi_s};
      end
      if (byte_done) begin
        if (!have_cmd) begin
          have_cmd  <= 1'b1;
          is_single <= rx_byte[3];
          is_read   <= rx_byte[2];
          used      <= rx_byte[2] & rx_byte[3];
          if (rx_byte[2]) begin
            tx_sh <= rd_val(rx_byte[7:4], time_in, ctl1_q, ctl2_q);
            if (!rx_byte[3]) begin
              shadow <= time_in;
              addr   <= rx_byte[7:4] + 4'd1;
            end else begin
              addr   <= rx_byte[7:4];
            end
          end else begin
            addr <= rx_byte[7:4];
          end
        end else if (is_read) begin
          if (is_single) tx_sh <= 8'h00;
          else begin
            tx_sh <= rd_val(addr, shadow, ctl1_q, ctl2_q);
            addr  <= addr + 4'd1;
          end
        end else begin
          if (commit) used <= 1'b1;
          if (!is_single) addr <= addr + 4'd1;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tm_we    <= 1'b0;
      tm_waddr <= '0;
      tm_wdata <= '0;
      ctl1_q   <= CTL1_RESET;
      ctl2_q   <= CTL2_RESET;
    end else begin
      tm_we <= wr_time;
      if (wr_time) begin
        tm_waddr <= addr[2:0];
        tm_wdata <= rx_byte;
      end
      if (wr_ctl1) ctl1_q <= rx_byte;
      ctl2_q <= (wr_ctl2 ? ((rx_byte & ~FLAG_MASK) | (ctl2_q & rx_byte & FLAG_MASK)) : ctl2_q)
              | {1'b0, low_volt_set, 1'b0, osc_stop_set, 4'b0000};
    end
endmodule

// File: rtl/rtc_spi_regif_chk.sv
module rtc_spi_regif_chk #(
  parameter int NUM_TIME = 7
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tm_we,
  input logic [2:0]            tm_waddr,
  input logic [7:0]            ctl1_q,
  input logic [7:0]            ctl2_q,
  input logic                  osc_stop_set,
  input logic                  low_volt_set,
  input logic                  wr_ctl1,
  input logic                  wr_ctl2,
  input logic                  cs_on,
  input logic                  have_cmd,
  input logic                  is_read,
  input logic                  is_single,
  input logic [NUM_TIME*8-1:0] shadow
);
  AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tm_we |=> !tm_we); // R6
  AST_WE_TIME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    tm_we |-> (tm_waddr != 3'd7)); // R8
  AST_OSC_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    osc_stop_set |=> ctl2_q[4]); // R10
  AST_LV_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    low_volt_set |=> ctl2_q[6]); // R10
  AST_FLAG_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ctl2_q[4]) || $fell(ctl2_q[6])) |-> $past(wr_ctl2)); // R10
  AST_CTL1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_ctl1) |-> $stable(ctl1_q)); // R9
  AST_SNAPSHOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (have_cmd && $past(have_cmd) && is_read && !is_single) |-> $stable(shadow)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_on |=> !tm_we); // R11
endmodule

bind rtc_spi_regif rtc_spi_regif_chk #(.NUM_TIME(NUM_TIME)) chk (
  .clk(clk), .rst_n(rst_n), .tm_we(tm_we), .tm_waddr(tm_waddr),
  .ctl1_q(ctl1_q), .ctl2_q(ctl2_q), .osc_stop_set(osc_stop_set),
  .low_volt_set(low_volt_set), .wr_ctl1(wr_ctl1), .wr_ctl2(wr_ctl2),
  .cs_on(cs_on), .have_cmd(have_cmd), .is_read(is_read),
  .is_single(is_single), .shadow(shadow)
);

// File: tb/tb_rtc_spi_regif.sv
module tb_rtc_spi_regif;
  logic clk = 0, rst_n = 0;
  logic spi_sclk = 0, spi_cs = 0, spi_mosi = 0;
  logic spi_miso;
  logic [55:0] time_in = '0;
  logic osc_stop_set = 0, low_volt_set = 0;
  logic tm_we;
  logic [2:0] tm_waddr;
  logic [7:0] tm_wdata, ctl1_q, ctl2_q;

  always #2 clk = ~clk;

  rtc_spi_regif dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs(spi_cs),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .time_in(time_in),
    .osc_stop_set(osc_stop_set), .low_volt_set(low_volt_set),
    .tm_we(tm_we), .tm_waddr(tm_waddr), .tm_wdata(tm_wdata),
    .ctl1_q(ctl1_q), .ctl2_q(ctl2_q)
  );

  int n_chk = 0, n_bad = 0;
  int we_n = 0;
  logic [2:0] we_a [16];
  logic [7:0] we_d [16];
  logic [7:0] ctl1_m = 8'h00, ctl2_m = 8'h10;
  logic [55:0] pat;

  always @(negedge clk)
    if (tm_we) begin
      if (we_n < 16) begin
        we_a[we_n] = tm_waddr;
        we_d[we_n] = tm_wdata;
      end
      we_n++;
    end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic halfp(); repeat (8) @(negedge clk); endtask
  task automatic fstart(); spi_cs = 1; halfp(); endtask
  task automatic fend(); spi_cs = 0; spi_mosi = 0; repeat (10) @(negedge clk); endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      spi_sclk = 1; spi_mosi = tx[i];
      halfp();
      rx[i] = spi_miso;
      spi_sclk = 0;
      halfp();
    end
  endtask

  function automatic logic [7:0] expect_rd(input logic [3:0] a, input logic [55:0] t);
    if (a == 0) return {1'b0, t[6:0]};
    if (a <= 6) return t[a*8 +: 8];
    if (a == 14) return ctl1_m;
    if (a == 15) return ctl2_m;
    return 8'h00;
  endfunction

  function automatic logic [7:0] ctl2_after(input logic [7:0] old, input logic [7:0] d);
    return (d & ~8'h50) | (old & d & 8'h50);
  endfunction

  function automatic logic [55:0] mkpat(input int seed);
    logic [55:0] p;
    for (int k = 0; k < 7; k++) p[k*8 +: 8] = 8'((seed * 29 + k * 53 + 131) ^ (k << 5));
    p[7] = 1'b1;
    return p;
  endfunction

  task automatic do_write(input logic [3:0] a, input logic [7:0] d);
    if (a == 14) ctl1_m = d;
    else if (a == 15) ctl2_m = ctl2_after(ctl2_m, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 miso", {7'b0, spi_miso}, 8'h00);
    chk("R1 tm_we", {7'b0, tm_we}, 8'h00);
    chk("R1 ctl1", ctl1_q, 8'h00);
    chk("R1 ctl2", ctl2_q, 8'h10);

    // R4 R8 R9 R2 R3: single read of every address, low command bits varied
    time_in = mkpat(1);
    for (int a = 0; a < 16; a++) begin
      fstart();
      xfer({4'(a), 2'b11, 2'(a)}, rx);
      chk("R3 miso during command", rx, 8'h00);
      xfer(8'h00, rx);
      chk(a >= 7 && a <= 13 ? "R8 unused reads zero" : "R4 single read", rx, expect_rd(4'(a), time_in));
      xfer(8'hFF, rx);
      chk("R4 extra byte reads zero", rx, 8'h00);
      fend();
    end

    // R5: burst read from every start, time changes after command
    for (int s = 0; s < 16; s++) begin
      pat = mkpat(s + 7);
      time_in = pat;
      fstart();
      xfer({4'(s), 4'h4}, rx);
      time_in = mkpat(s + 90);
      for (int k = 0; k < 8; k++) begin
        xfer(8'h00, rx);
        chk("R5 burst read snapshot", rx, expect_rd(4'(s + k), pat));
      end
      fend();
    end

    // R6 R8 R9 R10: single write to every address, second byte ignored
    for (int a = 0; a < 16; a++) begin
      logic [7:0] d;
      d = 8'(a * 17 + 8'h2B) | 8'h50;
      we_n = 0;
      fstart();
      xfer({4'(a), 4'h8}, rx);
      xfer(d, rx);
      xfer(~d, rx);
      fend();
      do_write(4'(a), d);
      chk("R6 strobe count", 8'(we_n), (a <= 6) ? 8'd1 : 8'd0);
      if (a <= 6 && we_n >= 1) begin
        chk("R6 strobe addr", {5'b0, we_a[0]}, 8'(a));
        chk("R6 strobe data", we_d[0], d);
      end
      chk("R9 ctl1 port", ctl1_q, ctl1_m);
      chk("R10 ctl2 port", ctl2_q, ctl2_m);
    end

    // R7: burst write 12..15,0,1 wraps
    we_n = 0;
    fstart();
    xfer(8'hC0, rx);
    for (int k = 0; k < 6; k++) begin
      xfer(8'(8'h61 + k * 9), rx);
      do_write(4'(12 + k), 8'(8'h61 + k * 9));
    end
    fend();
    chk("R7 burst strobe count", 8'(we_n), 8'd2);
    chk("R7 burst addr0", {5'b0, we_a[0]}, 8'd0);
    chk("R7 burst data0", we_d[0], 8'(8'h61 + 4 * 9));
    chk("R7 burst addr1", {5'b0, we_a[1]}, 8'd1);
    chk("R7 burst data1", we_d[1], 8'(8'h61 + 5 * 9));
    chk("R7 burst ctl1", ctl1_q, ctl1_m);
    chk("R7 burst ctl2", ctl2_q, ctl2_m);

    // R10: flags set, write 1 keeps, write 0 clears
    @(negedge clk) osc_stop_set = 1;
    @(negedge clk) osc_stop_set = 0; low_volt_set = 1;
    @(negedge clk) low_volt_set = 0;
    ctl2_m = ctl2_m | 8'h50;
    @(negedge clk);
    chk("R10 flags set", ctl2_q, ctl2_m);
    fstart(); xfer(8'hF8, rx); xfer(8'hFF, rx); fend();
    ctl2_m = ctl2_after(ctl2_m, 8'hFF);
    chk("R10 write ones keeps flags", ctl2_q, ctl2_m);
    fstart(); xfer(8'hFC, rx); xfer(8'h00, rx); fend();
    chk("R10 readback", rx, ctl2_m);
    fstart(); xfer(8'hF8, rx); xfer(8'h00, rx); fend();
    ctl2_m = 8'h00;
    chk("R10 write zero clears", ctl2_q, 8'h00);

    // R11: partial bytes discarded
    we_n = 0;
    fstart();
    xfer(8'hE8, rx);
    for (int i = 0; i < 5; i++) begin
      spi_sclk = 1; spi_mosi = 1; halfp(); spi_sclk = 0; halfp();
    end
    fend();
    chk("R11 partial ctl1 unchanged", ctl1_q, ctl1_m);
    fstart();
    xfer(8'h00, rx);
    for (int i = 0; i < 4; i++) begin
      spi_sclk = 1; spi_mosi = 1; halfp(); spi_sclk = 0; halfp();
    end
    fend();
    chk("R11 partial no strobe", 8'(we_n), 8'd0);
    time_in = mkpat(3);
    fstart(); xfer(8'h2C, rx); xfer(8'h00, rx); fend();
    chk("R11 next frame fresh command", rx, time_in[23:16]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule